// File: doc/BRIEF.md
# Wiper position counter with tap decode

This block keeps the volatile six-bit position of a digitally set resistor wiper and turns it into a registered one-of-64 switch-enable vector for the tap array. A position of 00h closes the switch at the low terminal. A position of 3Fh closes the switch at the high terminal. The array itself and any analog settling sit outside the block.

The position can change in four ways. A host command can write it directly. A host command can copy one of the stored data registers into it. While stepping is enabled by the command decoder, each serial clock high pulse moves it one tap, and the serial data level chosen during that pulse sets the direction. When reset is released, it is reloaded from stored data register 0.

All loads are single-cycle strobes from the command decoder. They carry no handshake and are never back-pressured: a strobe that loses arbitration in its cycle is dropped. The serial clock strobe must already be synchronised and must be one cycle wide for each high phase.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst_n` is low, `pos` is 0 and `tap_sel` has only bit 0 set.
- R2: On the first clock edge after `rst_n` rises, `pos` takes data register 0 (`dr_flat[5:0]`), and every other strobe in that cycle is ignored.
- R3: When `wr_valid` is high, `pos` takes `wr_data` on the next edge, for every value from 0 to 63.
- R4: When `xfr_valid` is high, `pos` takes data register k = `xfr_sel` on the next edge. Data register k is held in `dr_flat[6k+5:6k]`.
- R5: When `step_en` and `scl_hi_pulse` are both high and `sda_lvl` is 1, `pos` rises by one on the next edge.
- R6: When `step_en` and `scl_hi_pulse` are both high and `sda_lvl` is 0, `pos` falls by one on the next edge.
- R7: Stepping saturates. An up step at 63 leaves 63, and a down step at 0 leaves 0.
- R8: When several loads arrive in one cycle, the order of precedence is reset recall, then direct write, then transfer, then step.
- R9: A `scl_hi_pulse` while `step_en` is low leaves `pos` unchanged.
- R10: `tap_sel` always has exactly one bit set, at index `pos`, and it changes on the same edge as `pos`.
- R11: `pos` holds its value when no load fires, including when `step_en` is high and no pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release triggers the recall |
| dr_flat | input | 24 | Four stored 6-bit data registers, register k at bits 6k+5:6k |
| wr_valid | input | 1 | Direct write strobe |
| wr_data | input | 6 | Direct write value |
| xfr_valid | input | 1 | Transfer strobe |
| xfr_sel | input | 2 | Index of the data register to transfer |
| step_en | input | 1 | Step mode active |
| scl_hi_pulse | input | 1 | One-cycle strobe for each serial clock high phase |
| sda_lvl | input | 1 | Serial data level; 1 steps up, 0 steps down |
| pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | Registered one-hot switch enables |

## Verification
The bench builds the block with its default parameters: 6-bit position, four data registers and 64 taps. At this size every position can be written and checked against its one-hot tap, and an up step and a down step can be tried from each of the 64 values, so both saturation edges are reached. Runs of steps driven past each end, and every overlap of recall, write, transfer and step, check the arbitration.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RECALL,
    SRC_WRITE,
    SRC_XFR,
    SRC_STEP
  } load_src_e;
endpackage

// File: rtl/wpc_stepper.sv
module wpc_stepper #(
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] cur,
  input  logic             up,
  output logic [POS_W-1:0] nxt
);
  localparam logic [POS_W-1:0] TOP = '1;
  localparam logic [POS_W-1:0] BOT = '0;

  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
    else    nxt = (cur == BOT) ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/wpc_load_arb.sv
module wpc_load_arb
  import wpc_pkg::*;
#(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  parameter int SEL_W  = 2
) (
  input  logic [POS_W-1:0]        cur,
  input  logic                    recall_pend,
  input  logic [NUM_DR*POS_W-1:0] dr_flat,
  input  logic                    wr_valid,
  input  logic [POS_W-1:0]        wr_data,
  input  logic                    xfr_valid,
  input  logic [SEL_W-1:0]        xfr_sel,
  input  logic                    step_fire,
  input  logic [POS_W-1:0]        step_val,
  output logic [POS_W-1:0]        nxt
);
  logic [POS_W-1:0] dr_arr [NUM_DR];
  load_src_e        src;

  for (genvar k = 0; k < NUM_DR; k++) begin : g_dr
    assign dr_arr[k] = dr_flat[k*POS_W +: POS_W];
  end

  always_comb begin
    if (recall_pend)    src = SRC_RECALL;
    else if (wr_valid)  src = SRC_WRITE;
    else if (xfr_valid) src = SRC_XFR;
    else if (step_fire) src = SRC_STEP;
    else                src = SRC_NONE;

    case (src)
      SRC_RECALL: nxt = dr_arr[0];
      SRC_WRITE:  nxt = wr_data;
      SRC_XFR:    nxt = dr_arr[xfr_sel];
      SRC_STEP:   nxt = step_val;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/wpc_tap_decode.sv
module wpc_tap_decode #(
  parameter int POS_W = 6,
  parameter int TAPS  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_in,
  output logic [TAPS-1:0]  tap_q
);
  logic [TAPS-1:0] hot_nxt;

  for (genvar i = 0; i < TAPS; i++) begin : g_hot
    assign hot_nxt[i] = (pos_in == POS_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= {{(TAPS-1){1'b0}}, 1'b1};
    else        tap_q <= hot_nxt;
  end

  // R10: exactly one switch enable is active
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl #(
  parameter int POS_W  = 6,
  parameter int NUM_DR = 4,
  parameter int SEL_W  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  parameter int TAPS   = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_DR*POS_W-1:0] dr_flat,
  input  logic                    wr_valid,
  input  logic [POS_W-1:0]        wr_data,
  input  logic                    xfr_valid,
  input  logic [SEL_W-1:0]        xfr_sel,
  input  logic                    step_en,
  input  logic                    scl_hi_pulse,
  input  logic                    sda_lvl,
  output logic [POS_W-1:0]        pos,
  output logic [TAPS-1:0]         tap_sel
);
  localparam logic [POS_W-1:0] TOP = '1;

  logic [POS_W-1:0] pos_q, pos_nxt, step_val;
  logic             recall_pend, step_fire, quiet_hi;

  assign step_fire = step_en & scl_hi_pulse;

  wpc_stepper #(.POS_W(POS_W)) u_step (
    .cur(pos_q), .up(sda_lvl), .nxt(step_val)
  );

  wpc_load_arb #(.POS_W(POS_W), .NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_arb (
    .cur(pos_q), .recall_pend(recall_pend), .dr_flat(dr_flat),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .xfr_valid(xfr_valid), .xfr_sel(xfr_sel),
    .step_fire(step_fire), .step_val(step_val), .nxt(pos_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      recall_pend <= 1'b1;
    end else begin
      pos_q       <= pos_nxt;
      recall_pend <= 1'b0;
    end
  end

  wpc_tap_decode #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_nxt), .tap_q(tap_sel)
  );

  assign pos      = pos_q;
  assign quiet_hi = !recall_pend && !wr_valid && !xfr_valid;

  p_recall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pend |=> pos == $past(dr_flat[POS_W-1:0]));
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !recall_pend) |=> pos == $past(wr_data));
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && step_fire && sda_lvl && pos != TOP) |=> pos == $past(pos) + 1'b1);
  p_step_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && step_fire && !sda_lvl && pos != '0) |=> pos == $past(pos) - 1'b1);
  p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && step_fire && sda_lvl && pos == TOP) |=> pos == TOP);
  p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && step_fire && !sda_lvl && pos == '0) |=> pos == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_hi && !step_fire) |=> $stable(pos));
  p_tap_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[pos] == 1'b1);
endmodule

// File: tb/wiper_pos_ctrl_tb.sv
module wiper_pos_ctrl_tb;
  localparam int PW = 6, ND = 4, SW = 2, NT = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [ND*PW-1:0] dr_flat;
  logic          wr_valid, xfr_valid, step_en, scl_hi_pulse, sda_lvl;
  logic [PW-1:0] wr_data, pos;
  logic [SW-1:0] xfr_sel;
  logic [NT-1:0] tap_sel;

  int total = 0, bad = 0;
  bit finished = 0;

  wiper_pos_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dr_flat(dr_flat),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .xfr_valid(xfr_valid), .xfr_sel(xfr_sel),
    .step_en(step_en), .scl_hi_pulse(scl_hi_pulse), .sda_lvl(sda_lvl),
    .pos(pos), .tap_sel(tap_sel)
  );

  function automatic logic [PW-1:0] dr_val(int k);
    return PW'((k * 13 + 7) % 64);
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int exp);
    logic [NT-1:0] hot;
    hot = '0;
    hot[exp] = 1'b1;
    total++;
    if (pos !== PW'(exp) || tap_sel !== hot) begin
      bad++;
      $display("FAIL %s pos=%0d tap=%h expected pos=%0d tap=%h", req, pos, tap_sel, exp, hot);
    end
  endtask

  task automatic do_write(int v);
    wr_valid = 1'b1; wr_data = PW'(v);
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic do_step(bit up);
    step_en = 1'b1; scl_hi_pulse = 1'b1; sda_lvl = up;
    cyc();
    scl_hi_pulse = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp;
    rst_n = 1'b0; wr_valid = 0; wr_data = '0; xfr_valid = 0; xfr_sel = '0;
    step_en = 0; scl_hi_pulse = 0; sda_lvl = 0;
    for (int k = 0; k < ND; k++) dr_flat[k*PW +: PW] = dr_val(k);
    repeat (3) cyc();
    check("R1", 0);

    // R2: recall wins over a write in the release cycle
    rst_n = 1'b1; wr_valid = 1'b1; wr_data = 6'd33;
    cyc();
    wr_valid = 1'b0;
    check("R2", dr_val(0));

    for (int v = 0; v < 64; v++) begin
      do_write(v);
      check("R3 R10", v);
    end
    repeat (2) cyc();
    check("R11", 63);

    do_write(20);
    step_en = 1'b0; scl_hi_pulse = 1'b1; sda_lvl = 1'b1;
    cyc();
    check("R9", 20);
    sda_lvl = 1'b0;
    cyc();
    scl_hi_pulse = 1'b0;
    check("R9", 20);
    step_en = 1'b1;
    cyc();
    check("R11", 20);
    step_en = 1'b0;

    for (int k = 0; k < ND; k++) begin
      xfr_valid = 1'b1; xfr_sel = SW'(k);
      cyc();
      xfr_valid = 1'b0;
      check("R4", dr_val(k));
    end

    for (int v = 0; v < 64; v++) begin
      do_write(v);
      do_step(1'b1);
      check(v == 63 ? "R7" : "R5", v == 63 ? 63 : v + 1);
      do_write(v);
      do_step(1'b0);
      check(v == 0 ? "R7" : "R6", v == 0 ? 0 : v - 1);
    end

    do_write(60);
    exp = 60;
    for (int i = 0; i < 6; i++) begin
      do_step(1'b1);
      exp = (exp == 63) ? 63 : exp + 1;
      check("R5 R7", exp);
    end
    for (int i = 0; i < 70; i++) begin
      do_step(1'b0);
      exp = (exp == 0) ? 0 : exp - 1;
      check("R6 R7", exp);
    end

    // R8 precedence
    do_write(10);
    wr_valid = 1'b1; wr_data = 6'd50; xfr_valid = 1'b1; xfr_sel = 2'd2;
    step_en = 1'b1; scl_hi_pulse = 1'b1; sda_lvl = 1'b1;
    cyc();
    wr_valid = 1'b0;
    check("R8", 50);
    xfr_sel = 2'd3;
    cyc();
    xfr_valid = 1'b0;
    check("R8", dr_val(3));
    cyc();
    scl_hi_pulse = 1'b0;
    check("R8", dr_val(3) + 1);

    // R1/R2 again after a mid-run reset, with a transfer pending
    rst_n = 1'b0;
    cyc();
    check("R1", 0);
    rst_n = 1'b1; xfr_valid = 1'b1; xfr_sel = 2'd1;
    cyc();
    xfr_valid = 1'b0;
    check("R2", dr_val(0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule